// File: doc/BRIEF.md
# Replacement Way Selector for a Set-Associative Cache

This block names the way that a set-associative cache should evict when a miss needs a line. For every set it keeps four pieces of bookkeeping: which ways hold a line, a recency age for each way, a round-robin fill pointer, and one shared pseudorandom generator. It does not hold any cache data or tags.

The cache controller uses three strobes. It reports hits with the access strobe, it reports completed line fills with the fill strobe, and it asks for a victim with the request strobe and a set index. The answer comes back in the same cycle. A two-bit mode input selects the policy at run time: reproducible pseudorandom, least-recently-used, or first-in-first-out. An empty way always takes priority over the policy's choice.

The controller only reports hits on ways that hold a line. When the associativity is one, the selector has no choice to make and always returns way 0.

Top module: `victim_way_sel`

## Requirements
- R1: After reset every way of every set is empty, the generator holds 0xACE1, each way's recency rank equals its way number (way 0 most recent), and each set's fill pointer is 0.
- R2: In every mode, if the requested set has an empty way, the victim is the lowest-numbered empty way. A fill marks its way as holding a line.
- R3: Mode encoding: 0 selects pseudorandom, 1 selects least-recently-used, 2 selects first-in-first-out, and 3 behaves exactly like 1.
- R4: In least-recently-used mode, a full set yields the way that has gone longest without a hit or a fill. Each hit and each fill makes its way the most recent, in every mode.
- R5: In first-in-first-out mode, a full set yields that set's fill pointer. The pointer advances by one, wrapping, on each fill to the set, and hits leave it unchanged.
- R6: In pseudorandom mode, a full set yields the two low bits of a 16-bit generator. The generator advances as {q[14:0], q[15]^q[13]^q[12]^q[10]} on every cycle with a victim request, in any mode, so the sequence repeats exactly after each reset.
- R7: The victim output is combinational: it reflects the state before the current cycle's updates and is valid in the cycle of the request.
- R8: When a hit and a fill name the same set in one cycle, only the fill changes the recency ranks.
- R9: With an associativity of one, the victim is always way 0.
- R10: Updates to one set leave every other set's victim unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy select (R3) |
| accValid | input | 1 | Hit report strobe |
| accSet | input | SET_W | Set of the hit |
| accWay | input | WAY_W | Way of the hit |
| fillValid | input | 1 | Fill report strobe |
| fillSet | input | SET_W | Set of the fill |
| fillWay | input | WAY_W | Way that was filled |
| vicReq | input | 1 | Victim request strobe |
| vicSet | input | SET_W | Set whose victim is requested |
| vicWay | output | WAY_W | Selected victim way |

## Verification
Cold sets filled one way at a time show that empty ways are preferred, lowest first. Directed hit sequences on a full set then separate true recency order from fill order: in first-in-first-out mode the same hits must leave the victim unchanged. A hit and a fill to the same set in one cycle show which of the two updates wins. Consecutive pseudorandom requests run across two resets, which shows the generator restarting and stepping once per request. A long mixed run over several sets, with the mode switching, compares every answer against a reference model built on ordered recency lists, and a one-way instance is watched alongside throughout.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;

  typedef enum logic [1:0] {
    MODE_RAND    = 2'd0,
    MODE_LRU     = 2'd1,
    MODE_FIFO    = 2'd2,
    MODE_LRU_ALT = 2'd3
  } selMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic recAccess;  // record hit in recency ranks
    logic recFill;    // record fill: valid, ranks, pointer
    logic stepRng;    // advance generator
    logic useLru;     // policy pick: recency
    logic useFifo;    // policy pick: fill order
  } selStrobe_t;

  localparam int          RNG_W     = 16;
  localparam logic [15:0] RNG_SEED  = 16'hACE1;
  localparam logic [15:0] RNG_TAPS  = 16'hB400;  // bits 15,13,12,10

endpackage

// File: rtl/victim_sel_ctrl.sv
module victim_sel_ctrl
  import victim_sel_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic             vicReq,
  input  logic [1:0]       mode,
  output selStrobe_t       strobe
);

  logic sameSetClash;
  selMode_e modeSel;

  assign modeSel      = selMode_e'(mode);
  assign sameSetClash = fillValid && (fillSet == accSet);

  always_comb begin
    strobe.recAccess = accValid && !sameSetClash;  // fill wins on clash
    strobe.recFill   = fillValid;
    strobe.stepRng   = vicReq;
    strobe.useLru    = (modeSel == MODE_LRU) || (modeSel == MODE_LRU_ALT);
    strobe.useFifo   = (modeSel == MODE_FIFO);
  end

endmodule

// File: rtl/victim_sel_dp.sv
module victim_sel_dp
  import victim_sel_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       strobe,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [SET_W-1:0] vicSet,
  output logic [WAY_W-1:0] vicWay
);

  generate
    if (NUM_WAYS == 1) begin : g_direct
      assign vicWay = '0;
    end else begin : g_assoc
      localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

      logic [NUM_WAYS-1:0] validQ [NUM_SETS];
      logic [WAY_W-1:0]    ageQ   [NUM_SETS][NUM_WAYS];
      logic [WAY_W-1:0]    ptrQ   [NUM_SETS];
      logic [RNG_W-1:0]    rngQ;

      logic             invFound;
      logic [WAY_W-1:0] invWay, lruWay, vicSel;

      function automatic logic [WAY_W-1:0] ageNext(
        input logic [WAY_W-1:0] cur,
        input logic [WAY_W-1:0] touched,
        input logic             isTarget
      );
        if (isTarget)           return '0;
        else if (cur < touched) return cur + 1'b1;
        else                    return cur;
      endfunction

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rngQ <= RNG_SEED;
          for (int s = 0; s < NUM_SETS; s++) begin
            validQ[s] <= '0;
            ptrQ[s]   <= '0;
            for (int w = 0; w < NUM_WAYS; w++) ageQ[s][w] <= WAY_W'(w);
          end
        end else begin
          if (strobe.stepRng) rngQ <= {rngQ[RNG_W-2:0], ^(rngQ & RNG_TAPS)};
          for (int s = 0; s < NUM_SETS; s++) begin
            if (strobe.recFill && fillSet == SET_W'(s)) begin
              validQ[s][fillWay] <= 1'b1;
              ptrQ[s] <= (ptrQ[s] == OLDEST) ? '0 : ptrQ[s] + 1'b1;
              for (int w = 0; w < NUM_WAYS; w++)
                ageQ[s][w] <= ageNext(ageQ[s][w], ageQ[s][fillWay], fillWay == WAY_W'(w));
            end else if (strobe.recAccess && accSet == SET_W'(s)) begin
              for (int w = 0; w < NUM_WAYS; w++)
                ageQ[s][w] <= ageNext(ageQ[s][w], ageQ[s][accWay], accWay == WAY_W'(w));
            end
          end
        end
      end

      always_comb begin
        invFound = 1'b0;
        invWay   = '0;
        lruWay   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
          if (!validQ[vicSet][w]) begin
            invFound = 1'b1;
            invWay   = WAY_W'(w);
          end
          if (ageQ[vicSet][w] == OLDEST) lruWay = WAY_W'(w);
        end
        if (invFound)           vicSel = invWay;
        else if (strobe.useFifo) vicSel = ptrQ[vicSet];
        else if (strobe.useLru)  vicSel = lruWay;
        else                     vicSel = rngQ[WAY_W-1:0];
      end

      assign vicWay = vicSel;
    end
  endgenerate

endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import victim_sel_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  parameter  int NUM_WAYS = 4,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             accValid,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             vicReq,
  input  logic [SET_W-1:0] vicSet,
  output logic [WAY_W-1:0] vicWay
);

  selStrobe_t strobe;

  victim_sel_ctrl #(.SET_W(SET_W)) u_ctrl (
    .accValid (accValid),
    .accSet   (accSet),
    .fillValid(fillValid),
    .fillSet  (fillSet),
    .vicReq   (vicReq),
    .mode     (mode),
    .strobe   (strobe)
  );

  victim_sel_dp #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .accSet (accSet),
    .accWay (accWay),
    .fillSet(fillSet),
    .fillWay(fillWay),
    .vicSet (vicSet),
    .vicWay (vicWay)
  );

endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 4,
  parameter int WAY_W    = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             accValid,
  input logic [SET_W-1:0] accSet,
  input logic [WAY_W-1:0] accWay,
  input logic             fillValid,
  input logic [SET_W-1:0] fillSet,
  input logic [WAY_W-1:0] fillWay,
  input logic             vicReq,
  input logic [SET_W-1:0] vicSet,
  input logic [WAY_W-1:0] vicWay
);

  logic fillSeen;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) fillSeen <= 1'b0;
    else if (fillValid) fillSeen <= 1'b1;

  // R2
  cold_way0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vicReq && !fillSeen) |-> (vicWay == '0));

  if (NUM_WAYS > 1) begin : g_multi
    // R4
    lru_hit_not_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
      (vicReq && mode[0] && $past(accValid) && !$past(fillValid) && $past(accSet) == vicSet)
        |-> (vicWay != $past(accWay)));

    // R4
    lru_fill_not_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
      (vicReq && mode[0] && $past(fillValid) && $past(fillSet) == vicSet)
        |-> (vicWay != $past(fillWay)));

    // R5
    fifo_hit_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
      (vicReq && mode == 2'd2 && $past(vicReq) && $past(mode) == 2'd2 &&
       $past(vicSet) == vicSet && !$past(fillValid))
        |-> (vicWay == $past(vicWay)));
  end

endmodule

bind victim_way_sel victim_sel_chk #(
  .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode),
  .accValid(accValid), .accSet(accSet), .accWay(accWay),
  .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
  .vicReq(vicReq), .vicSet(vicSet), .vicWay(vicWay)
);

// File: tb/tb_victim_way_sel.sv
module tb_victim_way_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 16;
  localparam int NWAYS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = '0;
  logic accValid = 1'b0, fillValid = 1'b0, vicReq = 1'b0;
  logic [3:0] accSet = '0, fillSet = '0, vicSet = '0;
  logic [1:0] accWay = '0, fillWay = '0;
  logic [1:0] vicWay;
  logic       vic1;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_way_sel #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS)) dut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .accValid(accValid), .accSet(accSet), .accWay(accWay),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .vicReq(vicReq), .vicSet(vicSet), .vicWay(vicWay));

  victim_way_sel #(.NUM_SETS(NSETS), .NUM_WAYS(1)) dut1w (
    .clk(clk), .rstN(rstN), .mode(mode),
    .accValid(accValid), .accSet(accSet), .accWay(1'b0),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(1'b0),
    .vicReq(vicReq), .vicSet(vicSet), .vicWay(vic1));

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  // reference model: ordered recency lists, fill pointers, generator
  bit          vld [NSETS][NWAYS];
  int          ord [NSETS][NWAYS];  // ord[s][0] = most recent
  int          fptr[NSETS];
  logic [15:0] rng;
  int          curMode = 0;

  typedef struct { int way; string tag; } exp_t;
  exp_t expQ[$];

  function automatic logic [15:0] rngNext(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  function automatic void modelReset();
    for (int s = 0; s < NSETS; s++) begin
      fptr[s] = 0;
      for (int w = 0; w < NWAYS; w++) begin vld[s][w] = 0; ord[s][w] = w; end
    end
    rng = 16'hACE1;
  endfunction

  function automatic void touch(input int s, input int w);
    int p = 0;
    for (int k = 0; k < NWAYS; k++) if (ord[s][k] == w) p = k;
    for (int k = p; k > 0; k--) ord[s][k] = ord[s][k-1];
    ord[s][0] = w;
  endfunction

  function automatic int expVictim(input int s);
    for (int w = 0; w < NWAYS; w++) if (!vld[s][w]) return w;
    case (curMode)
      0: return int'(rng[1:0]);
      2: return fptr[s];
      default: return ord[s][NWAYS-1];
    endcase
  endfunction

  task automatic cycle(input bit a, input int as, input int aw,
                       input bit f, input int fs, input int fw,
                       input bit r, input int rs, input string tag);
    exp_t e;
    @(negedge clk);
    mode = 2'(curMode);
    accValid = a;  accSet = 4'(as);  accWay = 2'(aw);
    fillValid = f; fillSet = 4'(fs); fillWay = 2'(fw);
    vicReq = r;    vicSet = 4'(rs);
    if (r) begin e.way = expVictim(rs); e.tag = tag; expQ.push_back(e); end
    if (f) begin vld[fs][fw] = 1; touch(fs, fw); fptr[fs] = (fptr[fs] + 1) % NWAYS; end
    if (a && !(f && fs == as)) touch(as, aw);
    if (r) rng = rngNext(rng);
  endtask

  task automatic req(input int s, input string tag);
    cycle(0, 0, 0, 0, 0, 0, 1, s, tag);
  endtask
  task automatic hit(input int s, input int w);
    cycle(1, s, w, 0, 0, 0, 0, 0, "");
  endtask
  task automatic fill(input int s, input int w);
    cycle(0, 0, 0, 1, s, w, 0, 0, "");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; accValid = 0; fillValid = 0; vicReq = 0;
    repeat (2) @(negedge clk);
    modelReset();
    rstN = 1;
  endtask

  // monitor: compares each request's answer in its own cycle (R7)
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rstN && vicReq) begin
      exp_t e;
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R7: unexpected request, actual %0d expected none", vicWay);
      end else begin
        e = expQ.pop_front();
        if (int'(vicWay) != e.way) begin
          testsFailed++;
          $display("FAIL %s: actual %0d expected %0d", e.tag, vicWay, e.way);
        end
      end
      testsRun++;
      if (vic1 !== 1'b0) begin
        testsFailed++;
        $display("FAIL R9: one-way victim actual %0d expected 0", vic1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    // R1, R2, R3: cold sets answer way 0 in every mode
    for (int m = 0; m < 4; m++) begin curMode = m; req(m, "R1"); end
    curMode = 1;
    fill(0, 0); fill(0, 1);
    req(0, "R2");                       // expect 2
    fill(0, 3); req(0, "R2");           // lowest empty is 2
    fill(0, 2);
    // R4: recency
    req(0, "R4");
    hit(0, 0); req(0, "R4");
    hit(0, 1); hit(0, 2); req(0, "R4");
    curMode = 3; hit(0, 3); req(0, "R3");
    // R10: other sets untouched
    req(5, "R10");
    // R5: fill order, hits ignored
    curMode = 2;
    req(0, "R5"); hit(0, 0); hit(0, 1); req(0, "R5");
    fill(0, 0); req(0, "R5"); fill(0, 1); req(0, "R5");
    // R8: hit and fill on same set in one cycle
    curMode = 1;
    for (int w = 0; w < NWAYS; w++) fill(1, w);
    cycle(1, 1, 0, 1, 1, 2, 0, 0, "");
    req(1, "R8"); hit(1, 0); req(1, "R8");
    // R6: generator sequence, repeats after reset
    for (int rep = 0; rep < 2; rep++) begin
      doReset();
      curMode = 1;
      for (int w = 0; w < NWAYS; w++) fill(3, w);
      curMode = 0;
      for (int k = 0; k < 12; k++) req(3, "R6");
    end
    // mixed run against the model
    for (int i = 0; i < 600; i++) begin
      int s = $urandom % 4;
      int aw = $urandom % NWAYS;
      bit a = ($urandom % 2) == 1;
      bit f = ($urandom % 4) == 0;
      if (i % 50 == 0) curMode = $urandom % 4;
      if (!vld[s][aw]) a = 0;
      cycle(a, s, aw, f, $urandom % 4, $urandom % NWAYS, 1, $urandom % 4, "R4/R5/R6 mixed");
    end
    @(negedge clk); vicReq = 0; accValid = 0; fillValid = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule